// File: doc/BRIEF.md
# Three-Format Integer Multiplier

This block multiplies two `WIDTH`-bit operands and returns the product in one of three formats. The format is chosen for each operation by a 2-bit mode input. A separate select input decides whether the operands are read as unsigned or as two's complement. The three formats are:

- the full double-width product;
- a single-width integer product with an overflow flag;
- a single-width fractional product, where the low-order product bits are dropped.

One multiplier array serves all three formats. A small formatting stage picks the bits each format needs. The same stage works out overflow from the upper product bits, which the single-width integer result would otherwise discard.

An operation is issued by raising `valid_i` with the operands, mode and select. The formatted result appears in the following cycle, flagged by `valid_o`. The mode travels with the operation, so back-to-back operations may each use a different format. When no operation is issued, the result registers keep their last value.

Top module: `mmul_multi`

## Requirements
- R1: With mode `00`, or the reserved mode `11`, `result_o` carries the complete 2·WIDTH-bit product. The product is unsigned when `signed_i`=0 and two's complement when `signed_i`=1.
- R2: With mode `01`, `result_o[WIDTH-1:0]` carries the low WIDTH product bits and `result_o[2·WIDTH-1:WIDTH]` is 0.
- R3: With mode `01`, `ovf_o`=1 exactly when the true product does not fit in WIDTH bits. For unsigned operands that means product ≥ 2^WIDTH. For signed operands it means the product lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1].
- R4: `ovf_o` is 0 for every operation issued with mode `00`, `10` or `11`.
- R5: With mode `10` the upper half of `result_o` is 0. The lower half depends on `signed_i`:
  - unsigned: product bits [2·WIDTH-1:WIDTH];
  - signed (operands as Q(WIDTH-1) fractions): product bits [2·WIDTH-2:WIDTH-1].
  In both cases the lower bits are simply truncated.
- R6: With mode `10` and `signed_i`=1, if both operands equal the most negative value (only the MSB set), the lower half of `result_o` saturates to the largest positive fraction (all bits set except the MSB).
- R7: `valid_o` rises exactly one cycle after each `valid_i`. The result shown is formatted with the mode and `signed_i` of that operation, even when consecutive operations use different modes.
- R8: In a cycle after which `valid_i` was 0, `valid_o` is 0 and `result_o` and `ovf_o` keep their previous values.
- R9: While `rst_ni` is low, `valid_o`, `ovf_o` and `result_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Issue an operation this cycle |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| mode_i | input | 2 | 00 double, 01 single integer, 10 fractional, 11 as 00 |
| signed_i | input | 1 | 1 selects two's complement operands |
| valid_o | output | 1 | Result is from the operation issued last cycle |
| result_o | output | 2·WIDTH | Formatted product |
| ovf_o | output | 1 | Single-width integer overflow |

## Verification
The bench drives the corners of each format, each of which has a typical failure:

- **Most-negative operands.** Squaring the most negative value is the one signed fractional case that must saturate. A design without the clamp returns the most negative fraction instead.
- **Zero, all-ones and mixed-sign operands in mode `01`.** These exercise the signed overflow window. A design that tests only the upper half, rather than the upper half plus the sign bit of the lower half, misses products such as 0x40·0x02.
- **Back-to-back operations with differing modes and signedness.** These expose a design that formats with the current inputs instead of the captured ones.
- **Idle gaps.** These catch a result register that is reloaded without `valid_i`.

// File: rtl/mmul_pkg.sv
package mmul_pkg;
  typedef enum logic [1:0] {
    MODE_DBL  = 2'b00,
    MODE_INT  = 2'b01,
    MODE_FRAC = 2'b10,
    MODE_RSVD = 2'b11
  } mmul_mode_e;
endpackage

// File: rtl/mmul_array.sv
// Shared multiplier: operands extended by one bit so one signed multiply covers both signednesses.
module mmul_array #(
  parameter int WIDTH = 8,
  localparam int EXT_W = WIDTH + 1,
  localparam int PRD_W = 2 * EXT_W
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             signed_i,
  output logic [PRD_W-1:0] prod_o
);
  logic signed [EXT_W-1:0] a_ext, b_ext;
  logic signed [PRD_W-1:0] prod_s;

  assign a_ext  = {signed_i & a_i[WIDTH-1], a_i};
  assign b_ext  = {signed_i & b_i[WIDTH-1], b_i};
  assign prod_s = PRD_W'(a_ext) * PRD_W'(b_ext);
  assign prod_o = prod_s;
endmodule

// File: rtl/mmul_ovf.sv
// Overflow of the single-width integer result, taken from the discarded upper bits.
module mmul_ovf #(
  parameter int WIDTH = 8,
  localparam int PRD_W = 2 * (WIDTH + 1),
  localparam int HI_W  = PRD_W - WIDTH + 1
) (
  input  logic [PRD_W-1:0] prod_i,
  input  logic             signed_i,
  output logic             ovf_o
);
  logic [HI_W-1:0] hi_bits;   // product bits PRD_W-1 .. WIDTH-1
  logic            uns_ovf, sgn_ovf;

  assign hi_bits = prod_i[PRD_W-1:WIDTH-1];
  assign uns_ovf = |hi_bits[HI_W-1:1];
  assign sgn_ovf = !((&hi_bits) || !(|hi_bits));
  assign ovf_o   = signed_i ? sgn_ovf : uns_ovf;
endmodule

// File: rtl/mmul_fmt.sv
// Picks the result bits for the selected format.
module mmul_fmt
  import mmul_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int PRD_W = 2 * (WIDTH + 1),
  localparam int RES_W = 2 * WIDTH
) (
  input  logic [PRD_W-1:0] prod_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       mode_i,
  input  logic             signed_i,
  input  logic             int_ovf_i,
  output logic [RES_W-1:0] result_o,
  output logic             ovf_o
);
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] MOST_POS = {1'b0, {(WIDTH-1){1'b1}}};

  logic             frac_sat;
  logic [WIDTH-1:0] frac_bits;

  assign frac_sat  = signed_i && (a_i == MOST_NEG) && (b_i == MOST_NEG);
  assign frac_bits = signed_i ? prod_i[RES_W-2:WIDTH-1] : prod_i[RES_W-1:WIDTH];

  always_comb begin
    result_o = '0;
    ovf_o    = 1'b0;
    unique case (mmul_mode_e'(mode_i))
      MODE_INT: begin
        result_o[WIDTH-1:0] = prod_i[WIDTH-1:0];
        ovf_o               = int_ovf_i;
      end
      MODE_FRAC: result_o[WIDTH-1:0] = frac_sat ? MOST_POS : frac_bits;
      default:   result_o = prod_i[RES_W-1:0];
    endcase
  end
endmodule

// File: rtl/mmul_multi.sv
module mmul_multi #(
  parameter int WIDTH = 8,
  localparam int PRD_W = 2 * (WIDTH + 1),
  localparam int RES_W = 2 * WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       mode_i,
  input  logic             signed_i,
  output logic             valid_o,
  output logic [RES_W-1:0] result_o,
  output logic             ovf_o
);
  logic [PRD_W-1:0] prod;
  logic             int_ovf;
  logic [RES_W-1:0] res_d;
  logic             ovf_d;

  mmul_array #(.WIDTH(WIDTH)) u_array (
    .a_i(a_i), .b_i(b_i), .signed_i(signed_i), .prod_o(prod)
  );

  mmul_ovf #(.WIDTH(WIDTH)) u_ovf (
    .prod_i(prod), .signed_i(signed_i), .ovf_o(int_ovf)
  );

  mmul_fmt #(.WIDTH(WIDTH)) u_fmt (
    .prod_i(prod), .a_i(a_i), .b_i(b_i), .mode_i(mode_i), .signed_i(signed_i),
    .int_ovf_i(int_ovf), .result_o(res_d), .ovf_o(ovf_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      ovf_o    <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_d;
        ovf_o    <= ovf_d;
      end
    end
  end
endmodule

// File: rtl/mmul_multi_chk.sv
module mmul_multi_chk #(
  parameter int WIDTH = 8,
  localparam int RES_W = 2 * WIDTH
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [1:0]       mode_i,
  input logic             signed_i,
  input logic             valid_o,
  input logic [RES_W-1:0] result_o,
  input logic             ovf_o
);
  logic [WIDTH-1:0] low_prod;
  assign low_prod = WIDTH'(a_i * b_i);

  a_r7_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o) && $stable(ovf_o)));

  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i != 2'b01) |=> !ovf_o);

  a_r2_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (mode_i == 2'b01 || mode_i == 2'b10)) |=> (result_o[RES_W-1:WIDTH] == '0));

  a_r2_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'b01) |=> (result_o[WIDTH-1:0] == $past(low_prod)));

  always_comb begin
    if (!rst_ni) a_r9_reset: assert (!valid_o && !ovf_o && result_o == '0);
  end
endmodule

bind mmul_multi mmul_multi_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/mmul_multi_tb_top.sv
`timescale 1ns/1ps
module mmul_multi_tb_top;
  localparam int W = 8;
  localparam int RW = 2 * W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid_i = 1'b0, signed_i = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [1:0] mode_i = 2'b00;
  logic valid_o, ovf_o;
  logic [RW-1:0] result_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [RW-1:0] exp_res_q[$];
  logic          exp_ovf_q[$];
  int            tag_q[$];

  always #4 clk = ~clk;

  mmul_multi #(.WIDTH(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .mode_i(mode_i), .signed_i(signed_i), .valid_o(valid_o),
    .result_o(result_o), .ovf_o(ovf_o)
  );

  // tag: 1 double, 2 int, 5 frac, 6 frac saturation
  task automatic model(input logic [W-1:0] a, input logic [W-1:0] b, input logic [1:0] m,
                       input logic s, output logic [RW-1:0] r, output logic o, output int tag);
    longint pa, pb, p;
    pa = s ? longint'($signed(a)) : longint'(a);
    pb = s ? longint'($signed(b)) : longint'(b);
    p  = pa * pb;
    r = '0; o = 1'b0;
    case (m)
      2'b01: begin
        r[W-1:0] = p[W-1:0];
        o = s ? (p < -(64'sd1 <<< (W-1)) || p > ((64'sd1 <<< (W-1)) - 1)) : (p >= (64'sd1 <<< W));
        tag = 2;
      end
      2'b10: begin
        if (s && a == 8'h80 && b == 8'h80) begin r[W-1:0] = 8'h7F; tag = 6; end
        else begin r[W-1:0] = s ? p[2*W-2:W-1] : p[2*W-1:W]; tag = 5; end
      end
      default: begin r = p[RW-1:0]; tag = 1; end
    endcase
  endtask

  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [1:0] m, input logic s);
    logic [RW-1:0] r; logic o; int tag;
    @(negedge clk);
    valid_i = 1'b1; a_i = a; b_i = b; mode_i = m; signed_i = s;
    model(a, b, m, s, r, o, tag);
    exp_res_q.push_back(r); exp_ovf_q.push_back(o); tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0; a_i = 8'($urandom); b_i = 8'($urandom);
      mode_i = 2'($urandom); signed_i = 1'($urandom);
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [RW-1:0] act,
                       input logic [RW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor / scoreboard
  logic [RW-1:0] last_res = '0;
  logic          last_ovf = 1'b0;
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      #1;
      if (valid_o) begin
        if (exp_res_q.size() == 0) begin
          check(1'b0, "R7 unexpected valid_o", RW'(valid_o), '0);
        end else begin
          logic [RW-1:0] er; logic eo; int tg; string rq, ro;
          er = exp_res_q.pop_front(); eo = exp_ovf_q.pop_front(); tg = tag_q.pop_front();
          case (tg)
            1: begin rq = "R1 double result"; ro = "R4 ovf in double"; end
            2: begin rq = "R2 single result"; ro = "R3 overflow"; end
            5: begin rq = "R5 fractional result"; ro = "R4 ovf in fractional"; end
            default: begin rq = "R6 fractional saturation"; ro = "R4 ovf in fractional"; end
          endcase
          check(result_o == er, rq, result_o, er);
          check(ovf_o == eo, ro, RW'(ovf_o), RW'(eo));
          last_res = er; last_ovf = eo;
        end
      end else begin
        check(result_o == last_res && ovf_o == last_ovf, "R8 hold when idle",
              {result_o[RW-2:0], ovf_o}, {last_res[RW-2:0], last_ovf});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 50000);
    check(1'b0, "watchdog expired", '0, '1);
    finish_run();
  end

  initial begin
    logic [W-1:0] corners[5] = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h01};
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(valid_o == 0 && ovf_o == 0 && result_o == '0, "R9 reset state",
          result_o, '0);
    rst_n = 1'b1;
    idle(2);
    // Directed corners: every mode x signedness x corner pair
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 2; s++)
        foreach (corners[i])
          foreach (corners[j])
            issue(corners[i], corners[j], 2'(m), 1'(s));
    idle(3);
    // R3 signed window edges and R6 saturation explicitly
    issue(8'h40, 8'h02, 2'b01, 1'b1);   // 128: overflows signed
    issue(8'hC0, 8'h02, 2'b01, 1'b1);   // -128: fits
    issue(8'h10, 8'h10, 2'b01, 1'b0);   // 256: overflows unsigned
    issue(8'h0F, 8'h11, 2'b01, 1'b0);   // 255: fits
    issue(8'h80, 8'h80, 2'b10, 1'b1);   // R6
    issue(8'h80, 8'h7F, 2'b10, 1'b1);
    idle(2);
    // R7: mode changes every cycle, random operands, random gaps
    for (int k = 0; k < 600; k++) begin
      issue(8'($urandom), 8'($urandom), 2'($urandom), 1'($urandom));
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(4);
    check(exp_res_q.size() == 0, "R7 missing results", RW'(exp_res_q.size()), '0);
    finish_run();
  end
endmodule